// File: doc/BRIEF.md
# AXI Response Latency Injector

This block sits on an AXI4 link between an upstream master and a downstream slave. It makes every read beat and every write response arrive later by a fixed, programmable number of clock cycles. The address, write-data and read-address channels pass straight through. Because the block never holds back request READY, a master that keeps several transactions outstanding can go on issuing requests at its normal rate. Only the time from a request to its response grows.

On the return path, each accepted R beat or B response goes into its own buffer together with the value of a free-running cycle counter. A per-entry "due" flag is set once the entry has aged by the configured latency. The master sees the buffer head only after that flag is set. The latency is the sum of a build-time parameter and a runtime input, so a test environment can change it between runs without rebuilding. The link carries the ID, address, burst length, data, strobe, last, response and handshake fields.

Top module: `axi_resp_delay`

## Requirements
- R1: The AW, W and AR channels are combinational wires in both directions: upstream VALID and payload appear on the downstream side, and downstream READY appears upstream. This holds in the same cycle, whatever the state of the response buffers.
- R2: The effective latency L, in clock cycles, is BASE_LAT plus the unsigned value on `lat_add`, computed without overflow. For example, BASE_LAT 0 with `lat_add` 20 gives L = 20.
- R3: A read beat taken from the downstream slave at clock edge E has `s_rvalid` low until edge E+max(L,1)-1 has passed. It is offered from then on, so with `s_rready` high the upstream handshake falls on edge E+max(L,1).
- R4: A write response taken downstream at edge E follows the same rule on `s_bvalid`: with `s_bready` high, the upstream handshake falls on edge E+max(L,1).
- R5: Read beats leave in the order they were accepted, with ID, data, response and last unchanged. Write responses keep their order, ID and response.
- R6: Once `s_rvalid` or `s_bvalid` is high, it stays high with a stable payload until the matching ready is seen. This holds even if `lat_add` changes meanwhile.
- R7: The read and write buffers hold R_DEPTH and B_DEPTH entries. When a buffer is full, `m_rready` or `m_bready` goes low. No response is dropped or duplicated.
- R8: When the buffer depth is at least max(L,1)+1 and the master keeps ready high, a stream of one response per cycle enters and leaves at one per cycle.
- R9: A synchronous active-low reset empties both buffers, drops responses that were still pending, drives `s_rvalid` and `s_bvalid` low and leaves `m_rready` and `m_bready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_add | input | LAT_W | Runtime latency added to BASE_LAT |
| s_awid | input | ID_W | Write address ID from master |
| s_awaddr | input | ADDR_W | Write address from master |
| s_awlen | input | LEN_W | Write burst length from master |
| s_awvalid | input | 1 | Write address valid from master |
| s_awready | output | 1 | Write address ready to master |
| s_wdata | input | DATA_W | Write data from master |
| s_wstrb | input | DATA_W/8 | Write strobes from master |
| s_wlast | input | 1 | Last write beat from master |
| s_wvalid | input | 1 | Write data valid from master |
| s_wready | output | 1 | Write data ready to master |
| s_bid | output | ID_W | Delayed write response ID |
| s_bresp | output | 2 | Delayed write response code |
| s_bvalid | output | 1 | Delayed write response valid |
| s_bready | input | 1 | Master accepts write response |
| s_arid | input | ID_W | Read address ID from master |
| s_araddr | input | ADDR_W | Read address from master |
| s_arlen | input | LEN_W | Read burst length from master |
| s_arvalid | input | 1 | Read address valid from master |
| s_arready | output | 1 | Read address ready to master |
| s_rid | output | ID_W | Delayed read beat ID |
| s_rdata | output | DATA_W | Delayed read data |
| s_rresp | output | 2 | Delayed read response code |
| s_rlast | output | 1 | Delayed last-beat flag |
| s_rvalid | output | 1 | Delayed read beat valid |
| s_rready | input | 1 | Master accepts read beat |
| m_awid | output | ID_W | Write address ID to slave |
| m_awaddr | output | ADDR_W | Write address to slave |
| m_awlen | output | LEN_W | Write burst length to slave |
| m_awvalid | output | 1 | Write address valid to slave |
| m_awready | input | 1 | Write address ready from slave |
| m_wdata | output | DATA_W | Write data to slave |
| m_wstrb | output | DATA_W/8 | Write strobes to slave |
| m_wlast | output | 1 | Last write beat to slave |
| m_wvalid | output | 1 | Write data valid to slave |
| m_wready | input | 1 | Write data ready from slave |
| m_bid | input | ID_W | Write response ID from slave |
| m_bresp | input | 2 | Write response code from slave |
| m_bvalid | input | 1 | Write response valid from slave |
| m_bready | output | 1 | Block accepts write response |
| m_arid | output | ID_W | Read address ID to slave |
| m_araddr | output | ADDR_W | Read address to slave |
| m_arlen | output | LEN_W | Read burst length to slave |
| m_arvalid | output | 1 | Read address valid to slave |
| m_arready | input | 1 | Read address ready from slave |
| m_rid | input | ID_W | Read beat ID from slave |
| m_rdata | input | DATA_W | Read data from slave |
| m_rresp | input | 2 | Read response code from slave |
| m_rlast | input | 1 | Last-beat flag from slave |
| m_rvalid | input | 1 | Read beat valid from slave |
| m_rready | output | 1 | Block accepts read beat |

## Verification
The bench builds the block with BASE_LAT 0, a five-bit `lat_add` and four-entry buffers on both return paths. With BASE_LAT 0, a zero latency can be reached, which shows the single added register stage. The same settings also reach 20 and the maximum of 31. Four entries fill within a few beats, so buffer-full backpressure is easy to hit. At L = 3 the depth of four is exactly enough to show full-rate streaming.

// File: rtl/lat_inj_pkg.sv
package lat_inj_pkg;

  // Effective latency: build-time base plus runtime addition.
  function automatic int unsigned total_latency(input int unsigned base, input int unsigned extra);
    return base + extra;
  endfunction

  // True when an entry stamped at `stamp` has aged by at least `lat`
  // as of the counter value `now_next`, in a counter of `cw` bits.
  function automatic logic age_reached(input logic [31:0] now_next,
                                       input logic [31:0] stamp,
                                       input logic [31:0] lat,
                                       input int unsigned cw);
    logic [31:0] mask;
    logic [31:0] age;
    mask = (cw >= 32) ? 32'hFFFF_FFFF : ((32'd1 << cw) - 32'd1);
    age  = (now_next - stamp) & mask;
    return age >= lat;
  endfunction

  // Circular pointer step for a buffer of `depth` slots.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/lat_stamp_counter.sv
module lat_stamp_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] now,
  output logic [CNT_W-1:0] now_next
);
  assign now_next = now + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now_next;
  end
endmodule

// File: rtl/lat_resp_fifo.sv
module lat_resp_fifo
  import lat_inj_pkg::*;
#(
  parameter int PW    = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 8,
  parameter int LAT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] now,
  input  logic [CNT_W-1:0] now_next,
  input  logic [LAT_W-1:0] lat,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PW-1:0]    out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [PW-1:0]    slot_data  [DEPTH];
  logic [CNT_W-1:0] slot_stamp [DEPTH];
  logic [DEPTH-1:0] slot_ripe;
  logic [DEPTH-1:0] slot_due;
  logic             new_due;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;

  // Named events for the checks below.
  logic push_ev, pop_ev, buf_full, buf_empty;

  assign buf_full  = (occ == OCC_W'(DEPTH));
  assign buf_empty = (occ == '0);
  assign in_ready  = !buf_full;
  assign push_ev   = in_valid && in_ready;
  assign out_valid = !buf_empty && slot_ripe[rd_ptr];
  assign pop_ev    = out_valid && out_ready;
  assign out_data  = slot_data[rd_ptr];

  // Maturity test for each slot as of the coming edge.
  for (genvar g = 0; g < DEPTH; g++) begin : g_due
    assign slot_due[g] = age_reached(32'(now_next), 32'(slot_stamp[g]), 32'(lat), CNT_W);
  end
  assign new_due = age_reached(32'(now_next), 32'(now), 32'(lat), CNT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occ       <= '0;
      slot_ripe <= '0;
      for (int i = 0; i < DEPTH; i++) slot_stamp[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_ev && wr_ptr == PTR_W'(i)) begin
          slot_ripe[i]  <= new_due;
          slot_stamp[i] <= now;
        end else begin
          slot_ripe[i]  <= slot_ripe[i] | slot_due[i];
        end
      end
      if (push_ev) wr_ptr <= PTR_W'(ptr_step(32'(wr_ptr), DEPTH));
      if (pop_ev)  rd_ptr <= PTR_W'(ptr_step(32'(rd_ptr), DEPTH));
      case ({push_ev, pop_ev})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ev) slot_data[wr_ptr] <= in_data;
  end

  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_hold_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  assert_reset_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (buf_empty && !out_valid && in_ready));
endmodule

// File: rtl/axi_resp_delay.sv
module axi_resp_delay
  import lat_inj_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int LAT_W    = 6,
  parameter int BASE_LAT = 20,
  parameter int R_DEPTH  = 32,
  parameter int B_DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LAT_W-1:0]    lat_add,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [LEN_W-1:0]    s_awlen,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [ID_W-1:0]     s_bid,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ID_W-1:0]     s_arid,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [LEN_W-1:0]    s_arlen,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [ID_W-1:0]     s_rid,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rlast,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [LEN_W-1:0]    m_awlen,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [ID_W-1:0]     m_arid,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [LEN_W-1:0]    m_arlen,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [ID_W-1:0]     m_rid,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  input  logic                m_rvalid,
  output logic                m_rready
);
  localparam int EL_W  = LAT_W + 1;
  localparam int CNT_W = LAT_W + 2;
  localparam int R_PW  = ID_W + DATA_W + 3;
  localparam int B_PW  = ID_W + 2;

  // Request channels: plain wires in both directions.
  assign m_awid    = s_awid;
  assign m_awaddr  = s_awaddr;
  assign m_awlen   = s_awlen;
  assign m_awvalid = s_awvalid;
  assign s_awready = m_awready;
  assign m_wdata   = s_wdata;
  assign m_wstrb   = s_wstrb;
  assign m_wlast   = s_wlast;
  assign m_wvalid  = s_wvalid;
  assign s_wready  = m_wready;
  assign m_arid    = s_arid;
  assign m_araddr  = s_araddr;
  assign m_arlen   = s_arlen;
  assign m_arvalid = s_arvalid;
  assign s_arready = m_arready;

  logic [EL_W-1:0]  lat_eff;
  logic [CNT_W-1:0] now, now_next;
  assign lat_eff = EL_W'(total_latency(BASE_LAT, 32'(lat_add)));

  lat_stamp_counter #(.CNT_W(CNT_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .now(now), .now_next(now_next)
  );

  logic [R_PW-1:0] r_in, r_out;
  assign r_in = {m_rid, m_rdata, m_rresp, m_rlast};
  assign {s_rid, s_rdata, s_rresp, s_rlast} = r_out;

  lat_resp_fifo #(.PW(R_PW), .DEPTH(R_DEPTH), .CNT_W(CNT_W), .LAT_W(EL_W)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .now(now), .now_next(now_next), .lat(lat_eff),
    .in_valid(m_rvalid), .in_ready(m_rready), .in_data(r_in),
    .out_valid(s_rvalid), .out_ready(s_rready), .out_data(r_out)
  );

  logic [B_PW-1:0] b_in, b_out;
  assign b_in = {m_bid, m_bresp};
  assign {s_bid, s_bresp} = b_out;

  lat_resp_fifo #(.PW(B_PW), .DEPTH(B_DEPTH), .CNT_W(CNT_W), .LAT_W(EL_W)) u_bbuf (
    .clk(clk), .rst_n(rst_n), .now(now), .now_next(now_next), .lat(lat_eff),
    .in_valid(m_bvalid), .in_ready(m_bready), .in_data(b_in),
    .out_valid(s_bvalid), .out_ready(s_bready), .out_data(b_out)
  );
endmodule

// File: tb/axi_resp_delay_test.sv
module axi_resp_delay_test;
  localparam int ID_W = 4, ADDR_W = 16, DATA_W = 16, LEN_W = 8, LAT_W = 5;
  localparam int BASE_LAT = 0, R_DEPTH = 4, B_DEPTH = 4;
  localparam int NV = 6;
  localparam int VLAT [NV] = '{0, 1, 2, 5, 13, 20};
  localparam int VEXP [NV] = '{1, 1, 2, 5, 13, 20};

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [LAT_W-1:0] lat_add = '0;
  logic [ID_W-1:0] s_awid = '0, s_arid = '0, s_bid, s_rid, m_awid, m_arid;
  logic [ID_W-1:0] m_bid = '0, m_rid = '0;
  logic [ADDR_W-1:0] s_awaddr = '0, s_araddr = '0, m_awaddr, m_araddr;
  logic [LEN_W-1:0] s_awlen = '0, s_arlen = '0, m_awlen, m_arlen;
  logic [DATA_W-1:0] s_wdata = '0, m_wdata, s_rdata, m_rdata = '0;
  logic [DATA_W/8-1:0] s_wstrb = '0, m_wstrb;
  logic [1:0] s_bresp, s_rresp, m_bresp = '0, m_rresp = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_wlast = 0, s_arvalid = 0, s_bready = 1, s_rready = 1;
  logic m_awready = 0, m_wready = 0, m_arready = 0, m_bvalid = 0, m_rvalid = 0, m_rlast = 0;
  logic s_awready, s_wready, s_arready, s_bvalid, s_rvalid, s_rlast;
  logic m_awvalid, m_wvalid, m_wlast, m_arvalid, m_bready, m_rready;

  axi_resp_delay #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .LAT_W(LAT_W), .BASE_LAT(BASE_LAT), .R_DEPTH(R_DEPTH), .B_DEPTH(B_DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .lat_add(lat_add),
    .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bid(s_bid), .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_arid(s_arid), .s_araddr(s_araddr), .s_arlen(s_arlen), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rid(s_rid), .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bid(m_bid), .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_arid(m_arid), .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rid(m_rid), .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  // Handshake logs: edge numbers and upstream payloads.
  int dn_r_n = 0, up_r_n = 0, dn_b_n = 0, up_b_n = 0;
  int dn_r_edge [64], up_r_edge [64], dn_b_edge [64], up_b_edge [64];
  logic [31:0] up_r_pl [64], up_b_pl [64];

  always @(negedge clk) begin
    if (m_rvalid && m_rready && dn_r_n < 64) begin dn_r_edge[dn_r_n] = cyc + 1; dn_r_n++; end
    if (m_bvalid && m_bready && dn_b_n < 64) begin dn_b_edge[dn_b_n] = cyc + 1; dn_b_n++; end
    if (s_rvalid && s_rready && up_r_n < 64) begin
      up_r_edge[up_r_n] = cyc + 1; up_r_pl[up_r_n] = 32'({s_rid, s_rdata, s_rresp, s_rlast}); up_r_n++;
    end
    if (s_bvalid && s_bready && up_b_n < 64) begin
      up_b_edge[up_b_n] = cyc + 1; up_b_pl[up_b_n] = 32'({s_bid, s_bresp}); up_b_n++;
    end
  end

  function automatic logic [31:0] rpack(input int id, input int d, input int resp, input bit last);
    return 32'({ID_W'(id), DATA_W'(d), 2'(resp), last});
  endfunction
  function automatic logic [31:0] bpack(input int id, input int resp);
    return 32'({ID_W'(id), 2'(resp)});
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    dn_r_n = 0; up_r_n = 0; dn_b_n = 0; up_b_n = 0;
    dn_r_edge[0] = 0; up_r_edge[0] = 0; dn_b_edge[0] = 0; up_b_edge[0] = 0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Both beat tasks start and end 2 ns after a rising edge.
  task automatic rbeat(input int id, input int d, input int resp, input bit last);
    m_rvalid = 1; m_rid = ID_W'(id); m_rdata = DATA_W'(d); m_rresp = 2'(resp); m_rlast = last;
    @(negedge clk);
    while (!m_rready) @(negedge clk);
    @(posedge clk); #2;
    m_rvalid = 0;
  endtask

  task automatic bbeat(input int id, input int resp);
    m_bvalid = 1; m_bid = ID_W'(id); m_bresp = 2'(resp);
    @(negedge clk);
    while (!m_bready) @(negedge clk);
    @(posedge clk); #2;
    m_bvalid = 0;
  endtask

  initial begin
    int mism;
    wait_cycles(3);
    chk("R9", "rvalid in reset", s_rvalid, 0);
    chk("R9", "bvalid in reset", s_bvalid, 0);
    rst_n = 1;
    wait_cycles(1);
    chk("R9", "rvalid after reset", s_rvalid, 0);
    chk("R9", "m_rready after reset", m_rready, 1);
    chk("R9", "m_bready after reset", m_bready, 1);

    // Table of latencies and the expected handshake-to-handshake delays.
    for (int v = 0; v < NV; v++) begin
      clear_logs();
      lat_add = LAT_W'(VLAT[v]);
      s_rready = 1; s_bready = 1;
      rbeat(v, 16'hA000 + v, v % 4, 1'b1);
      bbeat(v + 8, (v + 1) % 4);
      wait_cycles(VEXP[v] + 4);
      chk("R3", "read beats out", up_r_n, 1);
      chk("R3", "read delay", up_r_edge[0] - dn_r_edge[0], VEXP[v]);
      chk("R4", "write resp out", up_b_n, 1);
      chk("R4", "write resp delay", up_b_edge[0] - dn_b_edge[0], VEXP[v]);
      chk("R5", "read payload", up_r_pl[0], rpack(v, 16'hA000 + v, v % 4, 1'b1));
      chk("R5", "write payload", up_b_pl[0], bpack(v + 8, (v + 1) % 4));
      if (VLAT[v] == 20) chk("R2", "latency base plus add", up_r_edge[0] - dn_r_edge[0], BASE_LAT + 20);
    end

    // Streaming at full rate with depth 4 and L = 3.
    clear_logs();
    lat_add = 3;
    for (int i = 0; i < 12; i++) rbeat(i, 16'h5000 + i, i % 4, (i % 4) == 3);
    wait_cycles(10);
    chk("R8", "downstream read span", dn_r_edge[11] - dn_r_edge[0], 11);
    chk("R8", "upstream read span", up_r_edge[11] - up_r_edge[0], 11);
    chk("R3", "stream first delay", up_r_edge[0] - dn_r_edge[0], 3);
    chk("R5", "stream read count", up_r_n, 12);
    mism = 0;
    for (int i = 0; i < 12; i++) if (up_r_pl[i] != rpack(i, 16'h5000 + i, i % 4, (i % 4) == 3)) mism++;
    chk("R5", "stream read order mismatches", mism, 0);
    clear_logs();
    for (int i = 0; i < 6; i++) bbeat(i + 2, i % 4);
    wait_cycles(10);
    chk("R8", "upstream write span", up_b_edge[5] - up_b_edge[0], 5);
    mism = 0;
    for (int i = 0; i < 6; i++) if (up_b_pl[i] != bpack(i + 2, i % 4)) mism++;
    chk("R5", "write order mismatches", mism, 0);

    // Read buffer full, master stalled.
    clear_logs();
    lat_add = 1; s_rready = 0;
    for (int i = 0; i < 4; i++) rbeat(i, 16'h7000 + i, 0, 1'b1);
    m_rvalid = 1; m_rid = 4; m_rdata = 16'h7004; m_rresp = 0; m_rlast = 1;
    wait_cycles(3);
    chk("R7", "m_rready when full", m_rready, 0);
    chk("R7", "beats taken when full", dn_r_n, 4);
    chk("R6", "rvalid held", s_rvalid, 1);
    chk("R6", "rdata held", s_rdata, 16'h7000);
    // Request channels while the read buffer is full.
    s_arvalid = 1; s_araddr = 16'h1234; s_arid = 3; s_arlen = 7; m_arready = 1;
    s_awvalid = 1; s_awaddr = 16'h4321; s_awlen = 2; m_awready = 0;
    s_wvalid = 1; s_wdata = 16'hBEEF; s_wstrb = 2'b10; s_wlast = 1; m_wready = 1;
    #1;
    chk("R1", "m_arvalid", m_arvalid, 1);
    chk("R1", "m_araddr", m_araddr, 16'h1234);
    chk("R1", "m_arlen", m_arlen, 7);
    chk("R1", "s_arready", s_arready, 1);
    chk("R1", "m_awaddr", m_awaddr, 16'h4321);
    chk("R1", "s_awready follows slave", s_awready, 0);
    chk("R1", "m_wdata", m_wdata, 16'hBEEF);
    chk("R1", "m_wstrb", m_wstrb, 2'b10);
    chk("R1", "s_wready", s_wready, 1);
    s_arvalid = 0; s_awvalid = 0; s_wvalid = 0;
    lat_add = 31;
    wait_cycles(3);
    chk("R6", "rvalid held over latency change", s_rvalid, 1);
    chk("R6", "rdata held over latency change", s_rdata, 16'h7000);
    lat_add = 1; s_rready = 1;
    @(negedge clk);
    while (!m_rready) @(negedge clk);
    @(posedge clk); #2;
    m_rvalid = 0;
    wait_cycles(10);
    chk("R7", "beats taken total", dn_r_n, 5);
    chk("R7", "beats delivered total", up_r_n, 5);
    mism = 0;
    for (int i = 0; i < 5; i++) if (up_r_pl[i] != rpack(i, 16'h7000 + i, 0, 1'b1)) mism++;
    chk("R5", "order after backpressure", mism, 0);

    // Write buffer full.
    clear_logs();
    s_bready = 0;
    for (int i = 0; i < 4; i++) bbeat(i, 1);
    m_bvalid = 1; m_bid = 9; m_bresp = 2;
    wait_cycles(3);
    chk("R7", "m_bready when full", m_bready, 0);
    s_bready = 1;
    @(negedge clk);
    while (!m_bready) @(negedge clk);
    @(posedge clk); #2;
    m_bvalid = 0;
    wait_cycles(10);
    chk("R7", "write responses delivered", up_b_n, 5);
    chk("R5", "last write payload", up_b_pl[4], bpack(9, 2));

    // Reset discards pending responses.
    clear_logs();
    s_rready = 0; lat_add = 1;
    rbeat(1, 16'h0101, 0, 1'b1);
    rbeat(2, 16'h0202, 0, 1'b1);
    wait_cycles(3);
    chk("R9", "rvalid before reset", s_rvalid, 1);
    rst_n = 0;
    wait_cycles(2);
    chk("R9", "rvalid cleared by reset", s_rvalid, 0);
    chk("R9", "m_rready in reset", m_rready, 1);
    rst_n = 1; s_rready = 1;
    wait_cycles(30);
    chk("R9", "no beat after flush", up_r_n, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule